// File: doc/BRIEF.md
# Strobe-Read Waveform Engine

This block is a bus master that pulls bytes, one per transaction, from an external 8-bit parallel source and pushes each one into a downstream FIFO. Each transaction walks a fixed strobe waveform. A one-cycle gap state holds the control lines at their idle code. A run of lead states then drives the strobe code, one clock each. A sample state follows, which also drives the strobe code and waits for the ready input. When ready is high, the byte on the data input is written into the FIFO.

Software starts the engine by writing a command byte. Transactions are limited by a loadable 32-bit transaction counter. With the flow enable input low, one command performs a single transaction. With it high, the engine keeps starting new transactions on its own while the FIFO has room, and stops once the count reaches zero. A count of 0x80000000 keeps the stream running for practical purposes. A done bit reports when the engine is idle. A masked, write-one-to-clear status register collects completion, expiry, stall and idle events into one interrupt line.

The states are IDLE, ARM (the gap and FIFO-space check), LEAD (strobe states 0 to LEAD-1) and SDP (the sample point). The transitions are:
- IDLE to ARM on an accepted command.
- ARM to LEAD when the FIFO is not full.
- LEAD to SDP after the last lead step.
- SDP back to ARM when flow is enabled and more than one transaction remains.
- SDP to IDLE in every other case.

Top module: `strobe_rd_engine`

## Requirements
- R1: After reset the control output is 0x7, the done bit (bit 7 of `trig_status`) is 1, `fifo_wr` is 0, the count is 0, and the status, enable and `irq` outputs are all 0.
- R2: A command is accepted only when the written byte is exactly 0x04, the engine is idle and the count is nonzero. Any other value, or a command with a zero count, leaves the engine idle and writes nothing.
- R3: Counting the edge that captures the command as edge 0, the control output is 0x7 for one cycle (ARM). It is then 0x1 for LEAD cycles (five by default), and 0x1 in the sample state that follows.
- R4: In the sample state the engine waits, writing nothing, until `rdy` is high. It then asserts `fifo_wr` for exactly that cycle with `fifo_data` equal to `din`.
- R5: The count loads from `tc_wdata` only while idle and decrements by one at each completed transaction. A count write while busy is ignored.
- R6: With `flow_en` low, one command performs one transaction and then the engine returns to idle.
- R7: With `flow_en` high, transactions repeat until the count reaches zero. Exactly as many bytes are written as the count that was loaded.
- R8: While `fifo_full` is high in the ARM state, no transaction starts and the control output stays 0x7. Transactions resume after it falls.
- R9: The done bit is 1 exactly while the engine is idle.
- R10: Status bits and the events that set them:
  - bit 0: each completed transaction
  - bit 2: the count reaching zero
  - bit 3: a return to idle
  - bit 4: a stall on a full FIFO in ARM
  - bit 5: a completion with `flow_en` low

  Bits 1, 6 and 7 read 0. Writing 1 to a bit clears it, and a set in the same cycle wins.
- R11: Only bits 0 and 2 to 5 of the enable register can be written (others read 0). `irq` is high exactly when some status bit and its enable bit are both 1.
- R12: A count of 0x80000000 keeps a flow-mode run busy, with the done bit at 0, for as long as it is observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_wr | input | 1 | Command write strobe |
| trig_wdata | input | 8 | Command byte (0x04 starts a read) |
| trig_status | output | 8 | Bit 7 done, other bits 0 |
| tc_wr | input | 1 | Transaction count write strobe |
| tc_wdata | input | 32 | Transaction count value |
| tc_left | output | 32 | Remaining transaction count |
| flow_en | input | 1 | Self re-trigger enable |
| ctl_out | output | 3 | Control lines to the source |
| rdy | input | 1 | Source ready |
| din | input | 8 | Parallel source byte |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| fifo_full | input | 1 | FIFO full flag |
| ie_wr | input | 1 | Interrupt enable write strobe |
| ie_wdata | input | 8 | Interrupt enable value |
| ie_value | output | 8 | Interrupt enable readback |
| is_clr_wr | input | 1 | Status clear strobe |
| is_clr_data | input | 8 | Bits to clear (write one to clear) |
| is_value | output | 8 | Interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a flow-mode stall landing exactly between two transactions. The full flag must rise after one byte is written and before the ARM state checks for space. A flag that rises one cycle later lets an extra transaction slip through. The bench counts write strobes itself and raises `fifo_full` at the drive point right after the second write's sample cycle. It then holds the flag long enough to confirm that the engine is parked in ARM and that the stall status bit is set. Random ready patterns with random counts exercise the sample-state wait, and a count written while a huge run is active checks that loads are refused when busy.

// File: rtl/wfe_pkg.sv
`timescale 1ns/1ps
package wfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_LEAD,
        ST_SDP
    } wfe_state_e;

    localparam int IRQ_WF    = 0;
    localparam int IRQ_TCEXP = 2;
    localparam int IRQ_DONE  = 3;
    localparam int IRQ_FFLAG = 4;
    localparam int IRQ_WF2   = 5;
    localparam logic [7:0] IRQ_MASK  = 8'h3D;
    localparam logic [7:0] CMD_START = 8'h04;
    localparam int DONE_BIT  = 7;
endpackage

// File: rtl/wfe_tcount.sv
`timescale 1ns/1ps
module wfe_tcount #(
    parameter int TCW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic [TCW-1:0] ld_val,
    input  logic           dec,
    output logic [TCW-1:0] cnt,
    output logic           last,
    output logic           zero
);
    localparam logic [TCW-1:0] ONE = TCW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);
    assign zero = (cnt == '0);

    // R5: one completion removes exactly one from the count
    p_dec_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    // R5: without load or completion the count holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !ld) |=> $stable(cnt));
endmodule

// File: rtl/wfe_irq.sv
`timescale 1ns/1ps
module wfe_irq
    import wfe_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] set_vec,
    input  logic          en_wr,
    input  logic [IW-1:0] en_data,
    input  logic          clr_wr,
    input  logic [IW-1:0] clr_data,
    output logic [IW-1:0] en_q,
    output logic [IW-1:0] status_q,
    output logic          irq
);
    localparam logic [IW-1:0] MASK = IW'(IRQ_MASK);

    logic [IW-1:0] clr_eff;
    logic [IW-1:0] status_nxt;

    always_comb begin
        clr_eff    = clr_wr ? clr_data : '0;
        status_nxt = ((status_q & ~clr_eff) | set_vec) & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            status_q <= '0;
        end else begin
            status_q <= status_nxt;
            if (en_wr) begin
                en_q <= en_data & MASK;
            end
        end
    end

    assign irq = |(status_q & en_q);

    // R10: an event always lands in status, even with a clear in the same cycle
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec & MASK)) == $past(set_vec & MASK)));

    // R10: a clear without a matching set removes the bit
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((clr_data & set_vec) == '0)) |=> ((status_q & $past(clr_data)) == '0));

    // R11: reserved enable bits never hold a one
    p_en_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~MASK) == '0);
endmodule

// File: rtl/wfe_seq.sv
`timescale 1ns/1ps
module wfe_seq
    import wfe_pkg::*;
#(
    parameter int              DW         = 8,
    parameter int              CTLW       = 3,
    parameter int              LEAD       = 5,
    parameter logic [CTLW-1:0] CTL_ACTIVE = 3'h1,
    parameter logic [CTLW-1:0] CTL_IDLE   = 3'h7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            flow_en,
    input  logic            fifo_full,
    input  logic            rdy,
    input  logic [DW-1:0]   din,
    input  logic            tc_last,
    output logic [CTLW-1:0] ctl,
    output logic            fifo_wr,
    output logic [DW-1:0]   fifo_data,
    output logic            xfer_done,
    output logic            idle,
    output logic            back_idle,
    output logic            stall_full
);
    localparam int              STEPW = (LEAD > 1) ? $clog2(LEAD) : 1;
    localparam logic [STEPW-1:0] LAST_STEP = STEPW'(LEAD - 1);

    wfe_state_e       state, state_nxt;
    logic [STEPW-1:0] step,  step_nxt;
    logic             keep_going;

    assign keep_going = flow_en && !tc_last;

    always_comb begin
        state_nxt = state;
        step_nxt  = step;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_ARM;
                end
            end
            ST_ARM: begin
                if (!fifo_full) begin
                    state_nxt = ST_LEAD;
                    step_nxt  = '0;
                end
            end
            ST_LEAD: begin
                if (step == LAST_STEP) begin
                    state_nxt = ST_SDP;
                end else begin
                    step_nxt = step + 1'b1;
                end
            end
            ST_SDP: begin
                if (rdy) begin
                    state_nxt = keep_going ? ST_ARM : ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_nxt;
            step  <= step_nxt;
        end
    end

    always_comb begin
        ctl        = CTL_IDLE;
        fifo_wr    = 1'b0;
        xfer_done  = 1'b0;
        idle       = 1'b0;
        back_idle  = 1'b0;
        stall_full = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle = 1'b1;
            end
            ST_ARM: begin
                stall_full = fifo_full;
            end
            ST_LEAD: begin
                ctl = CTL_ACTIVE;
            end
            ST_SDP: begin
                ctl       = CTL_ACTIVE;
                fifo_wr   = rdy;
                xfer_done = rdy;
                back_idle = rdy && !keep_going;
            end
            default: ctl = CTL_IDLE;
        endcase
    end

    assign fifo_data = din;

    // R3: the sample state is entered only from the final lead step
    p_sdp_after_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SDP && $past(state) != ST_SDP) |->
            ($past(state) == ST_LEAD && $past(step) == LAST_STEP));

    // R4: the sample state holds while the source is not ready
    p_sdp_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SDP && !rdy) |=> (state == ST_SDP));

    // R8: a full FIFO keeps the engine parked in the gap state
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && fifo_full) |=> (state == ST_ARM));

    // R6: without flow enable a completion always ends in idle
    p_single_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SDP && rdy && !flow_en) |=> (state == ST_IDLE));
endmodule

// File: rtl/strobe_rd_engine.sv
`timescale 1ns/1ps
module strobe_rd_engine
    import wfe_pkg::*;
#(
    parameter int DW   = 8,
    parameter int TCW  = 32,
    parameter int CTLW = 3,
    parameter int LEAD = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_wr,
    input  logic [7:0]      trig_wdata,
    output logic [7:0]      trig_status,
    input  logic            tc_wr,
    input  logic [TCW-1:0]  tc_wdata,
    output logic [TCW-1:0]  tc_left,
    input  logic            flow_en,
    output logic [CTLW-1:0] ctl_out,
    input  logic            rdy,
    input  logic [DW-1:0]   din,
    output logic            fifo_wr,
    output logic [DW-1:0]   fifo_data,
    input  logic            fifo_full,
    input  logic            ie_wr,
    input  logic [7:0]      ie_wdata,
    output logic [7:0]      ie_value,
    input  logic            is_clr_wr,
    input  logic [7:0]      is_clr_data,
    output logic [7:0]      is_value,
    output logic            irq
);
    localparam logic [CTLW-1:0] CTL_ACTIVE = CTLW'(1);
    localparam logic [CTLW-1:0] CTL_IDLE   = {CTLW{1'b1}};

    logic       start_hit;
    logic       tc_last, tc_zero;
    logic       xfer_done, seq_idle, back_idle, stall_full;
    logic [7:0] set_vec;

    assign start_hit = trig_wr && (trig_wdata == CMD_START) && !tc_zero;

    wfe_tcount #(.TCW(TCW)) u_tcount (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (tc_wr && seq_idle),
        .ld_val (tc_wdata),
        .dec    (xfer_done),
        .cnt    (tc_left),
        .last   (tc_last),
        .zero   (tc_zero)
    );

    wfe_seq #(
        .DW         (DW),
        .CTLW       (CTLW),
        .LEAD       (LEAD),
        .CTL_ACTIVE (CTL_ACTIVE),
        .CTL_IDLE   (CTL_IDLE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_hit),
        .flow_en    (flow_en),
        .fifo_full  (fifo_full),
        .rdy        (rdy),
        .din        (din),
        .tc_last    (tc_last),
        .ctl        (ctl_out),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .xfer_done  (xfer_done),
        .idle       (seq_idle),
        .back_idle  (back_idle),
        .stall_full (stall_full)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_WF]    = xfer_done;
        set_vec[IRQ_TCEXP] = xfer_done && tc_last;
        set_vec[IRQ_DONE]  = back_idle;
        set_vec[IRQ_FFLAG] = stall_full;
        set_vec[IRQ_WF2]   = xfer_done && !flow_en;
    end

    wfe_irq #(.IW(8)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .en_wr    (ie_wr),
        .en_data  (ie_wdata),
        .clr_wr   (is_clr_wr),
        .clr_data (is_clr_data),
        .en_q     (ie_value),
        .status_q (is_value),
        .irq      (irq)
    );

    always_comb begin
        trig_status           = '0;
        trig_status[DONE_BIT] = seq_idle;
    end

    // R5: a count write while busy leaves the count untouched
    p_busy_load_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_wr && !seq_idle && !xfer_done) |=> $stable(tc_left));

    // R2: a command with a zero count never leaves idle
    p_zero_count_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && tc_zero && !tc_wr) |=> seq_idle);

    // R9: the done bit and a write strobe never coexist
    p_done_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_status[DONE_BIT] |-> !fifo_wr);
endmodule

// File: tb/strobe_rd_engine_bench.sv
`timescale 1ns/1ps
module strobe_rd_engine_bench;
    localparam int DW = 8, TCW = 32, CTLW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            trig_wr = 1'b0;
    logic [7:0]      trig_wdata = '0;
    logic [7:0]      trig_status;
    logic            tc_wr = 1'b0;
    logic [TCW-1:0]  tc_wdata = '0;
    logic [TCW-1:0]  tc_left;
    logic            flow_en = 1'b0;
    logic [CTLW-1:0] ctl_out;
    logic            rdy = 1'b1;
    logic [DW-1:0]   din = '0;
    logic            fifo_wr;
    logic [DW-1:0]   fifo_data;
    logic            fifo_full = 1'b0;
    logic            ie_wr = 1'b0;
    logic [7:0]      ie_wdata = '0;
    logic [7:0]      ie_value;
    logic            is_clr_wr = 1'b0;
    logic [7:0]      is_clr_data = '0;
    logic [7:0]      is_value;
    logic            irq;

    int checks = 0;
    int errors = 0;
    int nwr    = 0;
    bit rdy_rand  = 1'b0;
    bit rdy_force = 1'b1;

    strobe_rd_engine u_strobe_rd_engine (
        .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
        .trig_status(trig_status), .tc_wr(tc_wr), .tc_wdata(tc_wdata),
        .tc_left(tc_left), .flow_en(flow_en), .ctl_out(ctl_out), .rdy(rdy),
        .din(din), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_full(fifo_full),
        .ie_wr(ie_wr), .ie_wdata(ie_wdata), .ie_value(ie_value),
        .is_clr_wr(is_clr_wr), .is_clr_data(is_clr_data), .is_value(is_value),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_ctl(input int i);
        return (i >= 2 && i <= 7) ? 3'h1 : 3'h7;
    endfunction

    function automatic logic [7:0] exp_flags(input bit flow, input bit expired, input bit stalled);
        logic [7:0] v;
        v = 8'h09;
        if (expired) v = v | 8'h04;
        if (!flow)   v = v | 8'h20;
        if (stalled) v = v | 8'h10;
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic load_tc(input logic [31:0] v);
        tc_wr = 1'b1; tc_wdata = v; tick(); tc_wr = 1'b0;
    endtask

    task automatic trig(input logic [7:0] v);
        trig_wr = 1'b1; trig_wdata = v; tick(); trig_wr = 1'b0;
    endtask

    task automatic wr_ie(input logic [7:0] v);
        ie_wr = 1'b1; ie_wdata = v; tick(); ie_wr = 1'b0;
    endtask

    task automatic clr_is(input logic [7:0] v);
        is_clr_wr = 1'b1; is_clr_data = v; tick(); is_clr_wr = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        int n = 0;
        @(negedge clk);
        while (!trig_status[7] && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    // source data and ready driver
    initial begin
        forever begin
            @(posedge clk);
            #3;
            din = 8'($urandom);
            rdy = rdy_rand ? (($urandom % 3) != 0) : rdy_force;
        end
    end

    // write monitor (R4)
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            nwr++;
            checks++;
            if (fifo_data !== din || ctl_out !== 3'h1) begin
                errors++;
                $display("FAIL R4 write actual=%0h/%0h expected=%0h/1", fifo_data, ctl_out, din);
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int seen;
        int n;
        void'($urandom(32'd4242));
        do_reset();

        // R1 reset state
        @(negedge clk);
        check("R1 ctl", 32'(ctl_out), 32'h7);
        check("R1 done", 32'(trig_status), 32'h80);
        check("R1 fifo_wr", 32'(fifo_wr), 0);
        check("R1 count", tc_left, 0);
        check("R1 status", 32'({is_value, ie_value}), 0);
        check("R1 irq", 32'(irq), 0);

        // R2 zero count: command ignored
        base = nwr;
        tick();
        trig(8'h04);
        repeat (12) tick();
        @(negedge clk);
        check("R2 zero-count done", 32'(trig_status[7]), 1);
        check("R2 zero-count writes", 32'(nwr - base), 0);

        // R2 wrong command values ignored
        load_tc(32'd2);
        @(negedge clk);
        check("R5 idle load", tc_left, 2);
        trig(8'h05);
        trig(8'h0C);
        trig(8'h00);
        repeat (12) tick();
        @(negedge clk);
        check("R2 bad cmd done", 32'(trig_status[7]), 1);
        check("R2 bad cmd writes", 32'(nwr - base), 0);
        check("R2 bad cmd count", tc_left, 2);

        // R3 R4 R6 R9 waveform timing, single shot
        tick();
        load_tc(32'd3);
        flow_en = 1'b0;
        trig(8'h04);
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            check($sformatf("R3 ctl cycle %0d", i), 32'(ctl_out), 32'(exp_ctl(i)));
            check($sformatf("R4 wr cycle %0d", i), 32'(fifo_wr), (i == 7) ? 1 : 0);
            check($sformatf("R9 busy cycle %0d", i), 32'(trig_status[7]), 0);
        end
        @(negedge clk);
        check("R6 idle after one", 32'(trig_status[7]), 1);
        check("R6 ctl idle", 32'(ctl_out), 32'h7);
        check("R5 count after one", tc_left, 2);
        check("R10 single flags", 32'(is_value), 32'(exp_flags(1'b0, 1'b0, 1'b0)));

        // R10 R11 masking and clearing
        tick();
        wr_ie(8'hFF);
        @(negedge clk);
        check("R11 enable mask", 32'(ie_value), 32'h3D);
        check("R11 irq on", 32'(irq), 1);
        tick();
        clr_is(8'h01);
        @(negedge clk);
        check("R10 w1c bit0", 32'(is_value), 32'h28);
        tick();
        wr_ie(8'h01);
        @(negedge clk);
        check("R11 irq masked", 32'(irq), 0);
        tick();
        wr_ie(8'h20);
        @(negedge clk);
        check("R11 irq bit5", 32'(irq), 1);
        tick();
        clr_is(8'hFF);
        wr_ie(8'h02);
        @(negedge clk);
        check("R10 clear all", 32'(is_value), 0);
        check("R11 reserved enable", 32'(ie_value), 0);
        check("R11 irq off", 32'(irq), 0);

        // R7 random flow runs
        for (int r = 0; r < 4; r++) begin
            tick();
            clr_is(8'hFF);
            n = 3 + int'($urandom % 20);
            load_tc(32'(n));
            flow_en  = 1'b1;
            rdy_rand = 1'b1;
            base = nwr;
            trig(8'h04);
            wait_done(2000);
            check($sformatf("R7 run %0d writes", r), 32'(nwr - base), 32'(n));
            check($sformatf("R7 run %0d count", r), tc_left, 0);
            check($sformatf("R10 run %0d flags", r), 32'(is_value), 32'(exp_flags(1'b1, 1'b1, 1'b0)));
        end
        rdy_rand = 1'b0;
        rdy_force = 1'b1;

        // R8 stall on full between transactions
        tick();
        clr_is(8'hFF);
        load_tc(32'd6);
        trig(8'h04);
        seen = 0;
        while (seen < 2) begin
            @(negedge clk);
            if (fifo_wr) seen++;
        end
        tick();
        fifo_full = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (fifo_wr) seen++;
        end
        check("R8 stalled writes", 32'(seen), 2);
        check("R8 stalled ctl", 32'(ctl_out), 32'h7);
        check("R8 stalled busy", 32'(trig_status[7]), 0);
        check("R10 stall flag", 32'(is_value[4]), 1);
        tick();
        fifo_full = 1'b0;
        while (!trig_status[7] && seen < 50) begin
            @(negedge clk);
            if (fifo_wr) seen++;
        end
        @(negedge clk);
        check("R8 resumed writes", 32'(seen), 6);
        check("R10 stall run flags", 32'(is_value), 32'(exp_flags(1'b1, 1'b1, 1'b1)));

        // R4 sample state waits for ready
        tick();
        clr_is(8'hFF);
        flow_en = 1'b0;
        rdy_force = 1'b0;
        load_tc(32'd1);
        base = nwr;
        trig(8'h04);
        repeat (20) tick();
        @(negedge clk);
        check("R4 held ctl", 32'(ctl_out), 32'h1);
        check("R4 held writes", 32'(nwr - base), 0);
        check("R4 held busy", 32'(trig_status[7]), 0);
        tick();
        rdy_force = 1'b1;
        wait_done(50);
        check("R4 released writes", 32'(nwr - base), 1);
        check("R10 expired single", 32'(is_value), 32'(exp_flags(1'b0, 1'b1, 1'b0)));

        // R5 R12 huge count, busy load ignored
        tick();
        flow_en = 1'b1;
        load_tc(32'h8000_0000);
        base = nwr;
        trig(8'h04);
        repeat (3) tick();
        load_tc(32'd5);
        repeat (300) tick();
        fifo_full = 1'b1;
        repeat (10) tick();
        @(negedge clk);
        check("R5 busy load ignored", tc_left, 32'h8000_0000 - 32'(nwr - base));
        check("R12 still busy", 32'(trig_status[7]), 0);
        check("R12 progress", 32'((nwr - base) > 30), 1);
        fifo_full = 1'b0;
        do_reset();
        @(negedge clk);
        check("R1 reset after run", tc_left, 0);
        check("R1 reset done", 32'(trig_status), 32'h80);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule